// File: doc/BRIEF.md
# Oversampling Serial Receiver with Tagged Receive Queue

This block is the receive half of one asynchronous serial channel. A 16x bit-rate enable (`tick16`) paces a small control machine. That machine passes the line through a two-stage synchroniser and hunts for a falling edge. It confirms the start bit half a bit later, then takes each data, parity and stop bit at the centre of its bit cell. The character length and parity mode come from static configuration inputs that the transmitter of the same channel also uses.

Each finished character goes into a 16-entry queue together with three error flags: parity mismatch, bad stop bit, and break. A frame that arrives while the queue is full is discarded, and `overrun` pulses for one cycle. A consumer sees `dataReady` while anything is queued. It pulses `rdStrobe` to pop the oldest entry onto `rdData` and `rdErr`. `fifoErr` tells the consumer that at least one queued entry carries an error, so it can decide to drain before trusting the data.

Top module: `serial_rx_core`

## Requirements
- R1: While reset is held and just after it, `dataReady`, `fifoErr` and `overrun` are 0, and `rdData` and `rdErr` are 0.
- R2: A start bit is a low line seen at a tick. Each later bit is sampled on the 8th tick of its cell, counting the detecting tick as the first, and every 16 ticks after that. Data arrives least significant bit first. `charLen` 0,1,2,3 selects 5,6,7,8 bits, and unused upper bits of `rdData` read 0.
- R3: If the line is high at the start-bit centre, the frame is discarded, nothing is stored, and hunting resumes.
- R4: When `parityEn`=1, a parity bit follows the data. `parityOdd`=0 means even and 1 means odd, counting data and parity ones together. A mismatch sets `rdErr[0]`. When `parityEn`=0 no parity bit is expected and `rdErr[0]` is 0.
- R5: Only one stop bit is sampled. A low stop bit sets `rdErr[1]`, and the receiver then waits to see the line high before it hunts again. After a good stop bit, hunting resumes at once, so back-to-back frames with one stop bit are received.
- R6: A frame that is entirely low (start, data, parity if enabled, stop) stores a single entry with data 0 and `rdErr`=3'b110, where bit 2 is break, bit 1 is framing and the parity flag is cleared. This holds however long the line stays low.
- R7: Up to 16 entries are kept and popped in arrival order. `dataReady` is 1 exactly when at least one entry is stored.
- R8: `rdStrobe` while `dataReady`=1 pops one entry, whose byte and flags appear on `rdData`/`rdErr` in the next cycle. Otherwise these outputs hold, and `rdStrobe` with an empty queue changes nothing.
- R9: A frame that completes while 16 entries are stored (occupancy taken before any same-cycle pop) is dropped. `overrun` is high for that one cycle, and the stored entries are unchanged.
- R10: `fifoErr` is 1 exactly when some stored entry has a nonzero error field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| serialIn | input | 1 | Asynchronous serial line, idle high |
| charLen | input | 2 | Data bits minus 5 |
| parityEn | input | 1 | Expect a parity bit |
| parityOdd | input | 1 | 1 = odd parity, 0 = even |
| rdStrobe | input | 1 | Pop the oldest entry |
| rdData | output | 8 | Byte of the last popped entry |
| rdErr | output | 3 | {break, framing, parity} of the last popped entry |
| dataReady | output | 1 | Queue not empty |
| fifoErr | output | 1 | Some queued entry carries an error |
| overrun | output | 1 | One-cycle pulse: a frame was dropped on a full queue |

## Verification
The receiver is driven with clean frames at every character length, with and without parity of both senses. These frames show that alignment, bit order and length masking are correct. Frames with a flipped parity bit, a low stop bit, a held-low line and a short low glitch separate the parity, framing, break and false-start paths from one another. Back-to-back frames with a single stop bit show that hunting resumes on time. A burst of seventeen unread frames, followed by in-order draining and reads of an empty queue, separates the overrun drop from ordinary storage and shows that the error summary follows the queue contents.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int MAX_BITS = 8;
  localparam int POS_W = $clog2(MAX_BITS);

  typedef enum logic [2:0] {
    ST_HUNT, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_WAITHI
  } rxState_e;

  // Strobes from the control machine to the datapath
  typedef struct packed {
    logic             clear;
    logic             takeData;
    logic [POS_W-1:0] bitPos;
    logic             takePar;
    logic             finish;
  } rxStrobe_t;

  typedef struct packed {
    logic                brk;
    logic                frm;
    logic                par;
    logic [MAX_BITS-1:0] data;
  } rxEntry_t;
endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      serialIn,
  input  logic [1:0] charLen,
  input  logic      parityEn,
  output logic      rxS,
  output rxStrobe_t strobe
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  rxState_e state;
  logic [CNT_W-1:0] tickCnt;
  logic [POS_W-1:0] bitCnt;
  logic atEnd, lastBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], serialIn};
  end
  assign rxS = syncQ[SYNC_STAGES-1];

  assign atEnd   = tick && (tickCnt == LAST);
  assign lastBit = (bitCnt == (POS_W'(charLen) + POS_W'(4)));

  always_comb begin
    strobe          = '0;
    strobe.bitPos   = bitCnt;
    strobe.clear    = (state == ST_HUNT) && tick && !rxS;
    strobe.takeData = (state == ST_DATA) && atEnd;
    strobe.takePar  = (state == ST_PAR)  && atEnd;
    strobe.finish   = (state == ST_STOP) && atEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (tick) begin
      case (state)
        ST_HUNT: if (!rxS) begin
          state   <= ST_START;
          tickCnt <= CNT_W'(1);
        end
        ST_START: begin
          if (tickCnt == MID) begin
            state   <= rxS ? ST_HUNT : ST_DATA;
            tickCnt <= '0;
            bitCnt  <= '0;
          end else tickCnt <= tickCnt + CNT_W'(1);
        end
        ST_DATA: begin
          if (tickCnt == LAST) begin
            tickCnt <= '0;
            bitCnt  <= bitCnt + POS_W'(1);
            if (lastBit) state <= parityEn ? ST_PAR : ST_STOP;
          end else tickCnt <= tickCnt + CNT_W'(1);
        end
        ST_PAR: begin
          if (tickCnt == LAST) begin
            tickCnt <= '0;
            state   <= ST_STOP;
          end else tickCnt <= tickCnt + CNT_W'(1);
        end
        ST_STOP: begin
          if (tickCnt == LAST) begin
            tickCnt <= '0;
            state   <= rxS ? ST_HUNT : ST_WAITHI;
          end else tickCnt <= tickCnt + CNT_W'(1);
        end
        ST_WAITHI: if (rxS) state <= ST_HUNT;
        default: state <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx_dpath.sv
module serial_rx_dpath
  import serial_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxS,
  input  rxStrobe_t           strobe,
  input  logic                parityEn,
  input  logic                parityOdd,
  input  logic                rdStrobe,
  output logic [MAX_BITS-1:0] rdData,
  output logic [2:0]          rdErr,
  output logic [CW-1:0]       fifoCount,
  output logic                fifoErr,
  output logic                overrun
);
  localparam int AW = $clog2(DEPTH);

  logic [MAX_BITS-1:0] shReg;
  logic parBit;
  rxEntry_t newEntry, headEntry, outEntry;
  rxEntry_t mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] errCnt;
  logic isFull, doPush, doPop, newBad, headBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      parBit <= 1'b0;
    end else if (strobe.clear) begin
      shReg  <= '0;
      parBit <= 1'b0;
    end else begin
      if (strobe.takeData) shReg[strobe.bitPos] <= rxS;
      if (strobe.takePar)  parBit <= rxS;
    end
  end

  always_comb begin
    newEntry.frm  = !rxS;
    newEntry.brk  = !rxS && (shReg == '0) && !parBit;
    newEntry.par  = parityEn && !newEntry.brk && ((^shReg) ^ parBit ^ parityOdd);
    newEntry.data = shReg;
  end

  assign headEntry = mem[rdPtr];
  assign isFull  = (fifoCount == CW'(DEPTH));
  assign doPush  = strobe.finish && !isFull;
  assign doPop   = rdStrobe && (fifoCount != '0);
  assign newBad  = newEntry.brk || newEntry.frm || newEntry.par;
  assign headBad = headEntry.brk || headEntry.frm || headEntry.par;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= newEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
      errCnt    <= '0;
      outEntry  <= '0;
      overrun   <= 1'b0;
    end else begin
      overrun <= strobe.finish && isFull;
      if (doPush) wrPtr <= wrPtr + AW'(1);
      if (doPop) begin
        rdPtr    <= rdPtr + AW'(1);
        outEntry <= headEntry;
      end
      case ({doPush, doPop})
        2'b10:   fifoCount <= fifoCount + CW'(1);
        2'b01:   fifoCount <= fifoCount - CW'(1);
        default: fifoCount <= fifoCount;
      endcase
      case ({doPush && newBad, doPop && headBad})
        2'b10:   errCnt <= errCnt + CW'(1);
        2'b01:   errCnt <= errCnt - CW'(1);
        default: errCnt <= errCnt;
      endcase
    end
  end

  assign rdData  = outEntry.data;
  assign rdErr   = {outEntry.brk, outEntry.frm, outEntry.par};
  assign fifoErr = (errCnt != '0);
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       serialIn,
  input  logic [1:0] charLen,
  input  logic       parityEn,
  input  logic       parityOdd,
  input  logic       rdStrobe,
  output logic [7:0] rdData,
  output logic [2:0] rdErr,
  output logic       dataReady,
  output logic       fifoErr,
  output logic       overrun
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  rxStrobe_t strobe;
  logic rxS;
  logic [CNT_W-1:0] fifoCount;

  serial_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick16), .serialIn(serialIn),
    .charLen(charLen), .parityEn(parityEn), .rxS(rxS), .strobe(strobe)
  );

  serial_rx_dpath #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) dpath_i (
    .clk(clk), .rstN(rstN), .rxS(rxS), .strobe(strobe),
    .parityEn(parityEn), .parityOdd(parityOdd), .rdStrobe(rdStrobe),
    .rdData(rdData), .rdErr(rdErr), .fifoCount(fifoCount),
    .fifoErr(fifoErr), .overrun(overrun)
  );

  assign dataReady = (fifoCount != '0);
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rstN,
  input logic          rdStrobe,
  input logic          dataReady,
  input logic [7:0]    rdData,
  input logic [2:0]    rdErr,
  input logic          fifoErr,
  input logic          overrun,
  input logic [CW-1:0] fifoCount
);
  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> $stable(rdData) && $stable(rdErr));

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CW'(DEPTH));

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount != $past(fifoCount)) |->
      ((fifoCount == $past(fifoCount) + CW'(1)) || (fifoCount == $past(fifoCount) - CW'(1))));

  // R9
  ovr_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> ($past(fifoCount) == CW'(DEPTH)));

  // R6
  brk_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdErr[2] |-> (rdErr[1] && !rdErr[0] && (rdData == 8'h00)));

  // R10
  ferr_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoErr |-> dataReady);
endmodule

bind serial_rx_core serial_rx_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .dataReady(dataReady),
  .rdData(rdData), .rdErr(rdErr), .fifoErr(fifoErr), .overrun(overrun),
  .fifoCount(fifoCount)
);

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb_top;
  localparam int TDIV    = 4;
  localparam int BIT_CYC = 16 * TDIV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick16 = 1'b0;
  logic serialIn = 1'b1;
  logic [1:0] charLen = 2'd3;
  logic parityEn = 1'b0;
  logic parityOdd = 1'b0;
  logic rdStrobe = 1'b0;
  logic [7:0] rdData;
  logic [2:0] rdErr;
  logic dataReady, fifoErr, overrun;

  int nChecks = 0;
  int nFail = 0;
  int divCnt = 0;
  bit sawOvr = 0;

  always #5 clk = ~clk;

  serial_rx_core dut_i (
    .clk(clk), .rstN(rstN), .tick16(tick16), .serialIn(serialIn),
    .charLen(charLen), .parityEn(parityEn), .parityOdd(parityOdd),
    .rdStrobe(rdStrobe), .rdData(rdData), .rdErr(rdErr),
    .dataReady(dataReady), .fifoErr(fifoErr), .overrun(overrun)
  );

  always @(negedge clk) begin
    divCnt = (divCnt + 1) % TDIV;
    tick16 <= (divCnt == 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit mS1 = 1, mS2 = 1;
  int mMode = 0, mTick = 0;
  logic [7:0] mData = 0;
  logic mPar = 0;
  logic [10:0] mQ[$];
  logic [7:0] expRd = 0;
  logic [2:0] expErr = 0;
  bit expOvr = 0;

  always @(posedge clk) begin
    bit rx, canPop, brk, frm, par;
    int k, nD;
    rx = mS2;
    if (!rstN) begin
      mS1 = 1; mS2 = 1; mMode = 0; mTick = 0; mQ.delete();
      expRd = 0; expErr = 0; expOvr = 0;
    end else begin
      canPop = rdStrobe && (mQ.size() > 0);
      expOvr = 0;
      if (tick16) begin
        if (mMode == 0) begin
          if (!rx) begin mMode = 1; mTick = 0; mData = 0; mPar = 0; end
        end else if (mMode == 2) begin
          if (rx) mMode = 0;
        end else begin
          mTick++;
          if (mTick == 7) begin
            if (rx) mMode = 0;
          end else if (mTick > 7 && (mTick - 7) % 16 == 0) begin
            k = (mTick - 7) / 16;
            nD = int'(charLen) + 5;
            if (k <= nD) mData[k-1] = rx;
            else if (parityEn && k == nD + 1) mPar = rx;
            else begin
              frm = !rx;
              brk = !rx && (mData == 0) && !mPar;
              par = parityEn && !brk && ((^mData) ^ mPar ^ parityOdd);
              if (mQ.size() == 16) expOvr = 1;
              else mQ.push_back({brk, frm, par, mData});
              mMode = rx ? 0 : 2;
            end
          end
        end
      end
      if (canPop) {expErr, expRd} = mQ.pop_front();
      mS2 = mS1; mS1 = serialIn;
    end
  end

  always @(negedge clk) begin
    bit anyErr;
    if (rstN) begin
      anyErr = 0;
      foreach (mQ[i]) if (mQ[i][10:8] != 0) anyErr = 1;
      chk("R7 dataReady", dataReady, mQ.size() != 0);
      chk("R10 fifoErr", fifoErr, anyErr);
      chk("R9 overrun", overrun, expOvr);
      chk("R8 rdData", rdData, expRd);
      chk("R8 rdErr", rdErr, expErr);
      if (overrun) sawOvr = 1;
    end
  end

  task automatic driveBit(input bit b);
    serialIn = b;
    repeat (BIT_CYC) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit stopVal, input bit flipPar);
    int n;
    bit p;
    n = int'(charLen) + 5;
    p = parityOdd;
    driveBit(0);
    for (int i = 0; i < n; i++) begin driveBit(d[i]); p ^= d[i]; end
    if (parityEn) driveBit(p ^ flipPar);
    driveBit(stopVal);
    serialIn = 1;
  endtask

  task automatic popCheck(input int expD, input int expE, input string tag);
    rdStrobe = 1;
    @(negedge clk);
    rdStrobe = 0;
    chk(tag, rdData, expD);
    chk(tag, rdErr, expE);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 dataReady", dataReady, 0);
    chk("R1 fifoErr", fifoErr, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 rdData", rdData, 0);
    chk("R1 rdErr", rdErr, 0);
    rstN = 1;
    repeat (BIT_CYC) @(negedge clk);
    chk("R1 idle dataReady", dataReady, 0);

    // R2 8 data bits, no parity
    sendFrame(8'hA5, 1, 0);
    driveBit(1);
    popCheck(8'hA5, 3'b000, "R2 8N1");

    // R2 5-bit with even parity, upper bits masked
    charLen = 2'd0; parityEn = 1; parityOdd = 0;
    sendFrame(8'hF3, 1, 0);
    driveBit(1);
    popCheck(8'h13, 3'b000, "R2 R4 5E1 masked");

    // R4 R10 odd parity, middle frame with bad parity
    charLen = 2'd2; parityOdd = 1;
    sendFrame(8'h5E, 1, 0);
    sendFrame(8'h55, 1, 1);
    sendFrame(8'h21, 1, 0);
    driveBit(1);
    chk("R10 error queued", fifoErr, 1);
    popCheck(8'h5E, 3'b000, "R4 odd good");
    chk("R10 still queued", fifoErr, 1);
    popCheck(8'h55, 3'b001, "R4 odd mismatch");
    chk("R10 cleared", fifoErr, 0);
    popCheck(8'h21, 3'b000, "R4 odd good 2");

    // R4 6-bit without parity
    charLen = 2'd1; parityEn = 0;
    sendFrame(8'h2A, 1, 0);
    driveBit(1);
    popCheck(8'h2A, 3'b000, "R4 no parity 6N1");

    // R3 false start
    charLen = 2'd3;
    serialIn = 0;
    repeat (4 * TDIV) @(negedge clk);
    serialIn = 1;
    repeat (3 * BIT_CYC) @(negedge clk);
    chk("R3 glitch dropped", dataReady, 0);

    // R5 framing error then recovery
    sendFrame(8'h5A, 0, 0);
    driveBit(1); driveBit(1);
    popCheck(8'h5A, 3'b010, "R5 framing");

    // R5 back-to-back single stop bit
    sendFrame(8'h11, 1, 0);
    sendFrame(8'h22, 1, 0);
    driveBit(1);
    popCheck(8'h11, 3'b000, "R5 back-to-back 1");
    popCheck(8'h22, 3'b000, "R5 back-to-back 2");

    // R6 long break yields one entry
    parityEn = 1; parityOdd = 0;
    serialIn = 0;
    repeat (30 * BIT_CYC) @(negedge clk);
    serialIn = 1;
    driveBit(1); driveBit(1);
    popCheck(8'h00, 3'b110, "R6 break");
    chk("R6 single entry", dataReady, 0);

    // R8 read on empty queue changes nothing
    popCheck(8'h00, 3'b110, "R8 empty read");

    // R9 overrun on seventeenth frame, then ordered drain
    parityEn = 0;
    sawOvr = 0;
    for (int i = 0; i < 17; i++) sendFrame(8'h30 + 8'(i), 1, 0);
    driveBit(1);
    chk("R9 overrun seen", sawOvr, 1);
    for (int i = 0; i < 16; i++) popCheck(8'h30 + i, 3'b000, "R7 R9 drain order");
    chk("R7 empty after drain", dataReady, 0);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule